// File: doc/BRIEF.md
# Next-PC and Branch/Jump Unit

This block decides where a RISC-V-like core fetches next. Each cycle it is handed the current program counter, the two register operands, an operation class, a comparison code and the offsets already extracted from the instruction word. From these it produces the next fetch address, a flag telling the front end that control flow left the straight line, the return address for link-writing jumps, and the PC-relative upper-immediate result. It is purely combinational. The register-operand comparison for conditional branches is evaluated inside it.

Branch and direct-jump displacements are expressed in halfword units. They are doubled, then sign-extended, then added to the PC. The register-indirect jump adds a sign-extended immediate to the first operand and forces bit 0 of the result low. Widths of the datapath and of every offset field are parameters. A parameter also chooses whether signed and unsigned ordering share one widened comparator or use two separate ones.

Top module: `npc_unit`

## Requirements
- R1: Operation class codes are sequential=0, branch=1, direct jump=2, indirect jump=3, upper-immediate=4. For classes 0, 4, 5, 6 and 7, next_pc_o equals pc_i + 4 and taken_o is 0.
- R2: For a branch, condition code 0 (equal) is taken when rs1_i == rs2_i. Condition code 1 (not equal) is taken when the two differ.
- R3: For a branch, condition code 2 (less, signed) is taken when rs1_i < rs2_i as two's complement. Code 3 (greater-or-equal, signed) is taken when that comparison fails.
- R4: For a branch, condition code 4 (less, unsigned) is taken when rs1_i < rs2_i as unsigned values. Code 5 (greater-or-equal, unsigned) is taken when that comparison fails.
- R5: A taken branch sets next_pc_o = pc_i + sign_extend(br_off_i << 1). A branch whose condition fails sets next_pc_o = pc_i + 4 with taken_o = 0.
- R6: Branch condition codes 6 and 7 are never taken.
- R7: Class 2 always asserts taken_o and sets next_pc_o = pc_i + sign_extend(jal_off_i << 1).
- R8: Class 3 always asserts taken_o and sets next_pc_o = (rs1_i + sign_extend(imm_i)) with bit 0 cleared.
- R9: link_o equals pc_i + 4 for every operation class.
- R10: auipc_o equals pc_i + (upper_i << 12) for every operation class.
- R11: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| op_i | input | 3 | Operation class |
| cond_i | input | 3 | Branch comparison code |
| br_off_i | input | 12 | Branch displacement in halfwords |
| jal_off_i | input | 20 | Direct-jump displacement in halfwords |
| imm_i | input | 12 | Indirect-jump byte offset |
| upper_i | input | 20 | Upper immediate |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control flow redirected |
| link_o | output | 32 | Return address |
| auipc_o | output | 32 | PC plus shifted upper immediate |

## Verification
The block holds no state, so a fault shows up in the same evaluation as the inputs that trigger it. Two places are most likely to go wrong. A comparator that mixes up signed and unsigned ordering only shows when the operands' top bits differ. A displacement that is not doubled, or is zero-extended, only shows for odd or negative offsets. Random operands are therefore biased toward equal values and mixed sign bits. Directed cases cover wrap-around at both ends of the address space and the odd indirect-jump target.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
   typedef enum logic [2:0] {
      NPC_OP_SEQ    = 3'd0,
      NPC_OP_BRANCH = 3'd1,
      NPC_OP_JAL    = 3'd2,
      NPC_OP_JALR   = 3'd3,
      NPC_OP_AUIPC  = 3'd4
   } npc_op_e;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_NE  = 3'd1,
      CMP_LT  = 3'd2,
      CMP_GE  = 3'd3,
      CMP_LTU = 3'd4,
      CMP_GEU = 3'd5
   } npc_cond_e;
endpackage

// File: rtl/npc_offset_add.sv
`timescale 1ns/1ps
// base + sign_extend(off << SHIFT), wrapping at XLEN bits
module npc_offset_add #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 12,
   parameter int SHIFT = 1
) (
   input  logic [XLEN-1:0]  base_i,
   input  logic [OFF_W-1:0] off_i,
   output logic [XLEN-1:0]  sum_o
);
   localparam int SH_W = OFF_W + SHIFT;

   if (SH_W > XLEN) begin : g_bad
      $error("npc_offset_add: shifted offset wider than datapath");
   end

   logic [SH_W-1:0] shifted;
   logic [XLEN-1:0] disp;

   if (SHIFT > 0) begin : g_shift
      assign shifted = {off_i, {SHIFT{1'b0}}};
   end else begin : g_noshift
      assign shifted = off_i;
   end

   if (SH_W < XLEN) begin : g_ext
      assign disp = {{(XLEN-SH_W){shifted[SH_W-1]}}, shifted};
   end else begin : g_full
      assign disp = shifted;
   end

   assign sum_o = base_i + disp;
endmodule

// File: rtl/npc_compare.sv
`timescale 1ns/1ps
module npc_compare
   import npc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_CMP = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [2:0]      cond_i,
   output logic            hold_o
);
   npc_cond_e cond;
   logic      use_signed;
   logic      eq;
   logic      lt;

   assign cond       = npc_cond_e'(cond_i);
   assign use_signed = (cond == CMP_LT) || (cond == CMP_GE);
   assign eq         = (a_i == b_i);

   if (SHARED_CMP) begin : g_shared
      // one XLEN+1 signed comparator; extension bit picks signedness
      logic [XLEN:0] a_w;
      logic [XLEN:0] b_w;
      assign a_w = {use_signed & a_i[XLEN-1], a_i};
      assign b_w = {use_signed & b_i[XLEN-1], b_i};
      assign lt  = $signed(a_w) < $signed(b_w);
   end else begin : g_split
      logic lt_s;
      logic lt_u;
      assign lt_s = $signed(a_i) < $signed(b_i);
      assign lt_u = a_i < b_i;
      assign lt   = use_signed ? lt_s : lt_u;
   end

   always_comb begin
      unique case (cond_i)
         CMP_EQ:           hold_o = eq;
         CMP_NE:           hold_o = !eq;
         CMP_LT, CMP_LTU:  hold_o = lt;
         CMP_GE, CMP_GEU:  hold_o = !lt;
         default:          hold_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int BR_OFF_W    = 12,
   parameter int JAL_OFF_W   = 20,
   parameter int IMM_W       = 12,
   parameter int UPPER_W     = 20,
   parameter int UPPER_SHIFT = 12,
   parameter int INSN_BYTES  = 4,
   parameter bit SHARED_CMP  = 1'b1
) (
   input  logic [XLEN-1:0]      pc_i,
   input  logic [XLEN-1:0]      rs1_i,
   input  logic [XLEN-1:0]      rs2_i,
   input  logic [2:0]           op_i,
   input  logic [2:0]           cond_i,
   input  logic [BR_OFF_W-1:0]  br_off_i,
   input  logic [JAL_OFF_W-1:0] jal_off_i,
   input  logic [IMM_W-1:0]     imm_i,
   input  logic [UPPER_W-1:0]   upper_i,
   output logic [XLEN-1:0]      next_pc_o,
   output logic                 taken_o,
   output logic [XLEN-1:0]      link_o,
   output logic [XLEN-1:0]      auipc_o
);
   localparam int          HALF_SHIFT = 1;
   localparam logic [XLEN-1:0] STEP   = XLEN'(INSN_BYTES);

   if (XLEN < 16) begin : g_chk_xlen
      $error("npc_unit: XLEN too small");
   end
   if (BR_OFF_W + HALF_SHIFT > XLEN || JAL_OFF_W + HALF_SHIFT > XLEN) begin : g_chk_off
      $error("npc_unit: displacement wider than datapath");
   end
   if (IMM_W > XLEN || UPPER_W + UPPER_SHIFT > XLEN) begin : g_chk_imm
      $error("npc_unit: immediate wider than datapath");
   end
   if (INSN_BYTES < 1) begin : g_chk_step
      $error("npc_unit: instruction size must be positive");
   end

   npc_op_e         op;
   logic            cond_hold;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jal_tgt;
   logic [XLEN-1:0] jalr_sum;

   assign op     = npc_op_e'(op_i);
   assign seq_pc = pc_i + STEP;

   npc_compare #(.XLEN(XLEN), .SHARED_CMP(SHARED_CMP)) i_cmp (
      .a_i(rs1_i), .b_i(rs2_i), .cond_i(cond_i), .hold_o(cond_hold)
   );

   npc_offset_add #(.XLEN(XLEN), .OFF_W(BR_OFF_W), .SHIFT(HALF_SHIFT)) i_br_add (
      .base_i(pc_i), .off_i(br_off_i), .sum_o(br_tgt)
   );

   npc_offset_add #(.XLEN(XLEN), .OFF_W(JAL_OFF_W), .SHIFT(HALF_SHIFT)) i_jal_add (
      .base_i(pc_i), .off_i(jal_off_i), .sum_o(jal_tgt)
   );

   npc_offset_add #(.XLEN(XLEN), .OFF_W(IMM_W), .SHIFT(0)) i_jalr_add (
      .base_i(rs1_i), .off_i(imm_i), .sum_o(jalr_sum)
   );

   npc_offset_add #(.XLEN(XLEN), .OFF_W(UPPER_W), .SHIFT(UPPER_SHIFT)) i_up_add (
      .base_i(pc_i), .off_i(upper_i), .sum_o(auipc_o)
   );

   always_comb begin
      next_pc_o = seq_pc;
      taken_o   = 1'b0;
      case (op)
         NPC_OP_BRANCH: begin
            taken_o = cond_hold;
            if (cond_hold) next_pc_o = br_tgt;
         end
         NPC_OP_JAL: begin
            taken_o   = 1'b1;
            next_pc_o = jal_tgt;
         end
         NPC_OP_JALR: begin
            taken_o   = 1'b1;
            next_pc_o = {jalr_sum[XLEN-1:1], 1'b0};
         end
         default: ;
      endcase
   end

   assign link_o = seq_pc;
endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
   parameter int XLEN       = 32,
   parameter int BR_OFF_W   = 12,
   parameter int JAL_OFF_W  = 20,
   parameter int INSN_BYTES = 4
) (
   input logic [XLEN-1:0]      pc_i,
   input logic [XLEN-1:0]      rs1_i,
   input logic [XLEN-1:0]      rs2_i,
   input logic [2:0]           op_i,
   input logic [2:0]           cond_i,
   input logic [BR_OFF_W-1:0]  br_off_i,
   input logic [JAL_OFF_W-1:0] jal_off_i,
   input logic [XLEN-1:0]      next_pc_o,
   input logic                 taken_o,
   input logic [XLEN-1:0]      link_o,
   input logic [XLEN-1:0]      auipc_o
);
   logic [XLEN-1:0] jal_disp;
   logic [XLEN-1:0] br_disp;
   assign jal_disp = {{(XLEN-JAL_OFF_W-1){jal_off_i[JAL_OFF_W-1]}}, jal_off_i, 1'b0};
   assign br_disp  = {{(XLEN-BR_OFF_W-1){br_off_i[BR_OFF_W-1]}}, br_off_i, 1'b0};

   always_comb begin
      if (op_i == 3'd0 || op_i >= 3'd4)
         assert_seq_no_redirect_R1: assert (!taken_o && next_pc_o == link_o)
            else $error("sequential class redirected");
      if (op_i == 3'd1 && !taken_o)
         assert_fallthrough_R5: assert (next_pc_o == link_o)
            else $error("untaken branch left straight line");
      if (op_i == 3'd1 && taken_o)
         assert_branch_disp_R5: assert (next_pc_o - pc_i == br_disp)
            else $error("branch displacement wrong");
      if (op_i == 3'd1 && cond_i >= 3'd6)
         assert_bad_cond_R6: assert (!taken_o)
            else $error("undefined condition taken");
      if (op_i == 3'd2)
         assert_jal_R7: assert (taken_o && (next_pc_o - pc_i) == jal_disp)
            else $error("direct jump wrong");
      if (op_i == 3'd3)
         assert_jalr_even_R8: assert (taken_o && !next_pc_o[0])
            else $error("indirect jump target odd or not taken");
      assert_link_step_R9: assert (link_o - pc_i == XLEN'(INSN_BYTES))
         else $error("link value wrong");
      assert_auipc_low_R10: assert (auipc_o[11:0] == pc_i[11:0])
         else $error("upper immediate disturbed low bits");
   end
endmodule

bind npc_unit npc_unit_chk #(
   .XLEN(XLEN), .BR_OFF_W(BR_OFF_W), .JAL_OFF_W(JAL_OFF_W), .INSN_BYTES(INSN_BYTES)
) i_npc_chk (
   .pc_i(pc_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .op_i(op_i), .cond_i(cond_i),
   .br_off_i(br_off_i), .jal_off_i(jal_off_i), .next_pc_o(next_pc_o),
   .taken_o(taken_o), .link_o(link_o), .auipc_o(auipc_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] pc, rs1, rs2;
   logic [2:0]  op, cond;
   logic [11:0] br_off, imm;
   logic [19:0] jal_off, upper;
   logic [31:0] next_pc, link, auipc;
   logic        taken;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   npc_unit i_npc_unit (
      .pc_i(pc), .rs1_i(rs1), .rs2_i(rs2), .op_i(op), .cond_i(cond),
      .br_off_i(br_off), .jal_off_i(jal_off), .imm_i(imm), .upper_i(upper),
      .next_pc_o(next_pc), .taken_o(taken), .link_o(link), .auipc_o(auipc)
   );

   function automatic bit exp_hold();
      case (cond)
         3'd0: return rs1 == rs2;
         3'd1: return rs1 != rs2;
         3'd2: return $signed(rs1) < $signed(rs2);
         3'd3: return !($signed(rs1) < $signed(rs2));
         3'd4: return rs1 < rs2;
         3'd5: return !(rs1 < rs2);
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit exp_taken();
      if (op == 3'd2 || op == 3'd3) return 1'b1;
      if (op == 3'd1) return exp_hold();
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_next();
      logic [31:0] s;
      case (op)
         3'd1: return exp_hold() ? pc + {{19{br_off[11]}}, br_off, 1'b0} : pc + 32'd4;
         3'd2: return pc + {{11{jal_off[19]}}, jal_off, 1'b0};
         3'd3: begin
            s = rs1 + {{20{imm[11]}}, imm};
            return {s[31:1], 1'b0};
         end
         default: return pc + 32'd4;
      endcase
   endfunction

   function automatic string tag_of();
      case (op)
         3'd1: case (cond)
                  3'd0, 3'd1: return "R2";
                  3'd2, 3'd3: return "R3";
                  3'd4, 3'd5: return "R4";
                  default:    return "R6";
               endcase
         3'd2: return "R7";
         3'd3: return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // inputs change on the rising edge; outputs are sampled on the falling edge
   task automatic check_now(string tag_override);
      string t;
      @(negedge clk);
      t = (tag_override != "") ? tag_override : tag_of();
      cmp(t, "taken", {31'd0, taken}, {31'd0, exp_taken()});
      cmp((op == 3'd1 && exp_taken()) ? "R5" : t, "next_pc", next_pc, exp_next());
      cmp("R9", "link", link, pc + 32'd4);
      cmp("R10", "auipc", auipc, pc + {upper, 12'd0});
   endtask

   task automatic apply(logic [31:0] p, logic [31:0] a, logic [31:0] b, logic [2:0] o,
                        logic [2:0] c, logic [11:0] bo, logic [19:0] jo,
                        logic [11:0] im, logic [19:0] up, string tg);
      @(posedge clk);
      pc = p; rs1 = a; rs2 = b; op = o; cond = c;
      br_off = bo; jal_off = jo; imm = im; upper = up;
      check_now(tg);
   endtask

   initial begin
      pc = '0; rs1 = '0; rs2 = '0; op = '0; cond = '0;
      br_off = '0; jal_off = '0; imm = '0; upper = '0;
      void'($urandom(32'h1357_9BDF));
      // idle state: everything zero, sequential
      check_now("R1");
      // R11 wrap at top of address space for sequential and jump
      apply(32'hFFFF_FFFC, 0, 0, 3'd0, 0, 0, 0, 0, 0, "R11");
      apply(32'h0000_0002, 0, 0, 3'd2, 0, 0, 20'hFFFFE, 0, 0, "R11");
      apply(32'hFFFF_F000, 0, 0, 3'd4, 0, 0, 0, 0, 20'h00001, "R11");
      // R8 odd target gets bit 0 cleared
      apply(32'h100, 32'h0000_2001, 0, 3'd3, 0, 0, 0, 12'h002, 0, "R8");
      apply(32'h100, 32'h0000_2000, 0, 3'd3, 0, 0, 0, 12'hFFF, 0, "R8");
      // R3 / R4 differ when signs differ
      apply(32'h400, 32'h8000_0000, 32'h1, 3'd1, 3'd2, 12'h010, 0, 0, 0, "R3");
      apply(32'h400, 32'h8000_0000, 32'h1, 3'd1, 3'd4, 12'h010, 0, 0, 0, "R4");
      apply(32'h400, 32'hFFFF_FFFF, 32'h0, 3'd1, 3'd5, 12'h010, 0, 0, 0, "R4");
      apply(32'h400, 32'h5, 32'h5, 3'd1, 3'd3, 12'h010, 0, 0, 0, "R3");
      // R5 negative branch displacement, R6 undefined codes
      apply(32'h400, 32'h7, 32'h7, 3'd1, 3'd0, 12'h800, 0, 0, 0, "R5");
      apply(32'h400, 32'h7, 32'h7, 3'd1, 3'd6, 12'h010, 0, 0, 0, "R6");
      apply(32'h400, 32'h7, 32'h8, 3'd1, 3'd7, 12'h010, 0, 0, 0, "R6");
      // R1 undefined classes behave sequentially
      apply(32'h800, 1, 1, 3'd5, 0, 12'h10, 20'h10, 0, 0, "R1");
      apply(32'h800, 1, 1, 3'd7, 0, 12'h10, 20'h10, 0, 0, "R1");
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] a, b;
         a = $urandom();
         b = ($urandom() % 4 == 0) ? a : $urandom();
         if ($urandom() % 4 == 0) b = {~a[31], b[30:0]};
         apply($urandom(), a, b, 3'($urandom() % 8), 3'($urandom() % 8),
               12'($urandom()), 20'($urandom()), 12'($urandom()), 20'($urandom()), "");
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule